// File: doc/BRIEF.md
# Serial EEPROM Page-Write Target

This block is a two-wire serial bus target that accepts byte and page writes into an internal byte array. It runs entirely on the system clock. The bus clock and data lines are oversampled through a short synchronizer. The target pulls the data line low through an open-drain enable output. A transfer has this shape:

- a start condition;
- a device address byte, which must carry the fixed pattern, the two strap bits and the write direction;
- a high word-address byte, then a low word-address byte;
- any number of data bytes.

Data bytes are gathered in a page latch of 64 entries, each with its own loaded flag. The low six address bits act as a pointer that wraps inside the page. A stop that follows at least one complete, acknowledged data byte starts a timed busy cycle. During that cycle the loaded entries are copied into the array, and the target ignores the bus completely, so the host can poll for completion by resending the device address until it is acknowledged. Any other stop, or a repeated start, drops the transfer and leaves the array untouched.

The rest of the chip reads the array through a plain registered read port. The array size is set by `MEM_AW`: the default of 11 gives 2 KB, and 13 gives the full 8 KB. The busy length `WR_CYCLES` defaults to about 5 ms at 200 MHz, and a bench can shorten it.

Control states are `ST_IDLE`, `ST_DEV`, `ST_DEV_ACK`, `ST_AHI`, `ST_AHI_ACK`, `ST_ALO`, `ST_ALO_ACK`, `ST_DATA`, `ST_DATA_ACK`, `ST_SKIP` and `ST_COMMIT`. The transitions are:

- Start outside `ST_COMMIT` goes to `ST_DEV`.
- Each receive state (`ST_DEV`, `ST_AHI`, `ST_ALO`, `ST_DATA`) moves to its acknowledge state on the falling bus clock after the eighth bit.
- `ST_DEV_ACK` goes to `ST_AHI` on a match, otherwise to `ST_SKIP`.
- `ST_AHI_ACK` goes to `ST_ALO`.
- `ST_ALO_ACK` and `ST_DATA_ACK` go to `ST_DATA`.
- Stop in `ST_DATA` at a byte boundary after a completed data byte goes to `ST_COMMIT`.
- Any other stop goes to `ST_IDLE`.
- `ST_COMMIT` returns to `ST_IDLE` when its countdown expires.

Top module: `eepw_target`

## Requirements
- R1: The device address byte is acknowledged only when its bits [7:3] equal 10100, bits [2:1] equal `strap_sel`, and bit 0 (direction) is 0. Acknowledge means `sda_oe` is high while the bus clock is high in the ninth clock of the byte. After a rejected device address, no later byte of that transfer is acknowledged.
- R2: The two bytes after the device address (high first, then low) are each acknowledged. They form a word address whose low `MEM_AW` bits select the array location. Bits of the high byte above the array width have no effect.
- R3: Every data byte is acknowledged. The byte is placed at the current pointer. After each byte, only the low 6 address bits advance, modulo 64, while the upper bits stay fixed. For example, 12 bytes from offset 60 land at offsets 60..63 and then 0..7 of the same page.
- R4: When more than 64 data bytes are sent, later bytes replace earlier ones at the same wrapped offset, and only the last value per offset is written.
- R5: A stop at a byte boundary after at least one complete, acknowledged data byte writes every loaded offset of the page. Offsets of that page that were not loaded keep their old contents.
- R6: A stop in the middle of a data byte, or before the first data byte and its acknowledge are complete, changes no location. In that case the target is immediately ready, so the next device address is acknowledged.
- R7: A repeated start during a write transfer drops it without changing any location.
- R8: After a committing stop, the target acknowledges no device address for `WR_CYCLES` clocks and ignores all bus traffic. Afterwards it acknowledges a matching device address again.
- R9: A device address with direction bit 1 is not acknowledged.
- R10: `rd_data` presents the array byte at `rd_addr` one clock after `rd_addr` is applied.
- R11: While and after reset, before any bus traffic, `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_sel | input | 2 | Strap value the device address bits [2:1] must match |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| rd_addr | input | MEM_AW | Array read address for the rest of the chip |
| rd_data | output | 8 | Array byte at the previous `rd_addr` |

## Verification
A wrong pointer or a lost loaded flag does not show on the bus. It shows only once the busy cycle ends, as a wrong or missing byte at some page offset on the read port. The bench therefore reads back the whole touched page after every transfer. A control state that runs ahead or behind shows within the same byte as a missing or misplaced acknowledge. A wrong commit decision shows on the first poll after the stop: that poll is acknowledged when it should not be, or refused when it should be.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP,
        ST_COMMIT
    } eepw_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } eepw_bus_ev_t;

endpackage

// File: rtl/eepw_line_sync.sv
module eepw_line_sync
    import eepw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_in,
    input  logic         sda_in,
    output eepw_bus_ev_t ev
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_sh;
    logic [MSB:0] sda_sh;
    logic         scl_p;
    logic         sda_p;
    logic         scl_s;
    logic         sda_s;

    // Idle bus level is high on both lines; reset to it so no false edge appears.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[MSB-1:0], scl_in};
            sda_sh <= {sda_sh[MSB-1:0], sda_in};
            scl_p  <= scl_sh[MSB];
            sda_p  <= sda_sh[MSB];
        end
    end

    assign scl_s = scl_sh[MSB];
    assign sda_s = sda_sh[MSB];

    always_comb begin
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/eepw_page_latch.sv
module eepw_page_latch #(
    parameter int OFF_W = 6,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_en_i,
    input  logic [OFF_W-1:0] wr_off_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic [OFF_W-1:0] rd_off_i,
    output logic [DW-1:0]    rd_data_o,
    output logic             rd_vld_o
);

    localparam int DEPTH = 1 << OFF_W;

    logic [DW-1:0] ent_q [DEPTH];
    logic          vld_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic hit;
        assign hit = wr_en_i && (wr_off_i == OFF_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
            end else if (clr_i) begin
                vld_q[g] <= 1'b0;
            end else if (hit) begin
                vld_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) begin
                ent_q[g] <= wr_data_i;
            end
        end
    end

    assign rd_data_o = ent_q[rd_off_i];
    assign rd_vld_o  = vld_q[rd_off_i];

endmodule

// File: rtl/eepw_store.sv
module eepw_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_o <= mem_q[raddr_i];
    end

endmodule

// File: rtl/eepw_target.sv
module eepw_target
    import eepw_pkg::*;
#(
    parameter int         MEM_AW      = 11,
    parameter int         PAGE_OFF_W  = 6,
    parameter int         WR_CYCLES   = 1_000_000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_ID      = 5'b10100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_sel,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int PAGE_BYTES = 1 << PAGE_OFF_W;
    localparam int PAGE_W     = MEM_AW - PAGE_OFF_W;
    localparam int HI_W       = MEM_AW - 8;
    localparam int BUSY_CYC   = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;
    localparam int TMR_W      = $clog2(BUSY_CYC + 1);

    eepw_bus_ev_t ev;

    eepw_state_e           state_q, state_d;
    logic [3:0]            bit_cnt_q;
    logic [7:0]            shreg_q;
    logic                  ack_q;
    logic [HI_W-1:0]       hi_q;
    logic [PAGE_W-1:0]     page_q;
    logic [PAGE_OFF_W-1:0] ptr_q;
    logic                  have_data_q;
    logic [TMR_W-1:0]      tmr_q;

    logic                  is_rx;
    logic                  is_ack;
    logic                  byte_end;
    logic                  dev_match;
    logic                  new_xfer;
    logic                  stop_commits;
    logic                  busy_done;

    logic                  lat_wr;
    logic [PAGE_OFF_W-1:0] com_off;
    logic [7:0]            lat_data;
    logic                  lat_vld;
    logic                  mem_we;
    logic                  in_window;

    eepw_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_in(scl_in),
        .sda_in(sda_in),
        .ev    (ev)
    );

    // ------------------------------------------------------------------
    // Decode helpers
    // ------------------------------------------------------------------
    always_comb begin
        is_rx  = (state_q == ST_DEV) || (state_q == ST_AHI) ||
                 (state_q == ST_ALO) || (state_q == ST_DATA);
        is_ack = (state_q == ST_DEV_ACK) || (state_q == ST_AHI_ACK) ||
                 (state_q == ST_ALO_ACK) || (state_q == ST_DATA_ACK);
        byte_end  = is_rx && ev.scl_fall && (bit_cnt_q == 4'd8);
        dev_match = (shreg_q[7:3] == DEV_ID) && (shreg_q[2:1] == strap_sel) && !shreg_q[0];
        new_xfer  = ev.start && (state_q != ST_COMMIT);
        // A stop's own rising clock shifts one bit, so a boundary stop sees at most one bit.
        stop_commits = (state_q == ST_DATA) && have_data_q && (bit_cnt_q <= 4'd1);
        busy_done    = (tmr_q == TMR_W'(BUSY_CYC - 1));
    end

    // ------------------------------------------------------------------
    // Next-state logic
    // ------------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        if (state_q == ST_COMMIT) begin
            if (busy_done) begin
                state_d = ST_IDLE;
            end
        end else if (ev.start) begin
            state_d = ST_DEV;
        end else if (ev.stop) begin
            state_d = stop_commits ? ST_COMMIT : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_SKIP:     state_d = ST_SKIP;
                ST_DEV:      if (byte_end)    state_d = ST_DEV_ACK;
                ST_DEV_ACK:  if (ev.scl_fall) state_d = ack_q ? ST_AHI : ST_SKIP;
                ST_AHI:      if (byte_end)    state_d = ST_AHI_ACK;
                ST_AHI_ACK:  if (ev.scl_fall) state_d = ST_ALO;
                ST_ALO:      if (byte_end)    state_d = ST_ALO_ACK;
                ST_ALO_ACK:  if (ev.scl_fall) state_d = ST_DATA;
                ST_DATA:     if (byte_end)    state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (ev.scl_fall) state_d = ST_DATA;
                ST_COMMIT:   state_d = ST_COMMIT;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // ------------------------------------------------------------------
    // State register
    // ------------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ------------------------------------------------------------------
    // Byte shifter, address pointer and busy timer
    // ------------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            ack_q       <= 1'b0;
            hi_q        <= '0;
            page_q      <= '0;
            ptr_q       <= '0;
            have_data_q <= 1'b0;
            tmr_q       <= '0;
        end else begin
            if (state_q == ST_COMMIT) begin
                tmr_q <= tmr_q + TMR_W'(1);
            end else begin
                tmr_q <= '0;
            end

            if (new_xfer) begin
                bit_cnt_q   <= '0;
                have_data_q <= 1'b0;
            end else if (state_q != ST_COMMIT) begin
                if (is_rx && ev.scl_rise) begin
                    shreg_q   <= {shreg_q[6:0], ev.sda};
                    bit_cnt_q <= bit_cnt_q + 4'd1;
                end
                if (byte_end) begin
                    ack_q <= (state_q == ST_DEV) ? dev_match : 1'b1;
                end
                if (byte_end && (state_q == ST_AHI)) begin
                    hi_q <= shreg_q[HI_W-1:0];
                end
                if (byte_end && (state_q == ST_ALO)) begin
                    {page_q, ptr_q} <= {hi_q, shreg_q};
                end
                if (is_ack && ev.scl_fall) begin
                    bit_cnt_q <= '0;
                end
                if ((state_q == ST_DATA_ACK) && ev.scl_fall) begin
                    ptr_q       <= ptr_q + PAGE_OFF_W'(1);
                    have_data_q <= 1'b1;
                end
            end
        end
    end

    // ------------------------------------------------------------------
    // Outputs: acknowledge drive and commit controls
    // ------------------------------------------------------------------
    always_comb begin
        sda_oe    = is_ack && ack_q;
        lat_wr    = byte_end && (state_q == ST_DATA);
        com_off   = tmr_q[PAGE_OFF_W-1:0];
        in_window = (state_q == ST_COMMIT) && (tmr_q < TMR_W'(PAGE_BYTES));
        mem_we    = in_window && lat_vld;
    end

    eepw_page_latch #(
        .OFF_W(PAGE_OFF_W),
        .DW   (8)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (new_xfer),
        .wr_en_i  (lat_wr),
        .wr_off_i (ptr_q),
        .wr_data_i(shreg_q),
        .rd_off_i (com_off),
        .rd_data_o(lat_data),
        .rd_vld_o (lat_vld)
    );

    eepw_store #(
        .AW(MEM_AW),
        .DW(8)
    ) u_store (
        .clk    (clk),
        .we_i   (mem_we),
        .waddr_i({page_q, com_off}),
        .wdata_i(lat_data),
        .raddr_i(rd_addr),
        .rdata_o(rd_data)
    );

endmodule

// File: rtl/eepw_target_chk.sv
module eepw_target_chk
    import eepw_pkg::*;
#(
    parameter int BUSY_CYC = 64,
    parameter int TMR_W    = 7,
    parameter int PTR_W    = 6,
    parameter int PAGE_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input eepw_state_e       state_q,
    input logic              sda_oe,
    input logic              mem_we,
    input logic [PTR_W-1:0]  ptr_q,
    input logic [PAGE_W-1:0] page_q,
    input logic              have_data_q,
    input logic [TMR_W-1:0]  tmr_q
);

    AST_ACK_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state_q inside {ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_DATA_ACK})); // R1

    AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |-> !sda_oe); // R8

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |-> (tmr_q < TMR_W'(BUSY_CYC))); // R8

    AST_WRITE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state_q == ST_COMMIT)); // R6

    AST_COMMIT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_COMMIT) && ($past(state_q) != ST_COMMIT)) |-> $past(have_data_q)); // R5

    AST_PTR_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DATA) && ($past(state_q) == ST_DATA_ACK)) |->
        (ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)))); // R3

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q inside {ST_DATA, ST_DATA_ACK, ST_COMMIT}) &&
         ($past(state_q) inside {ST_DATA, ST_DATA_ACK, ST_COMMIT})) |-> $stable(page_q)); // R3

endmodule

bind eepw_target eepw_target_chk #(
    .BUSY_CYC(BUSY_CYC),
    .TMR_W   (TMR_W),
    .PTR_W   (PAGE_OFF_W),
    .PAGE_W  (PAGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .sda_oe     (sda_oe),
    .mem_we     (mem_we),
    .ptr_q      (ptr_q),
    .page_q     (page_q),
    .have_data_q(have_data_q),
    .tmr_q      (tmr_q)
);

// File: tb/tb_eepw_target.sv
module tb_eepw_target;

    localparam int AW   = 11;
    localparam int WRC  = 400;
    localparam int HP   = 6;
    localparam int MEMN = 1 << AW;
    localparam int MAX_NACKS = WRC / 100 + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    strap = 2'b10;
    logic          m_scl = 1'b1;
    logic          m_low = 1'b0;
    logic          sda_oe;
    logic          sda_bus;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    always #2.5 clk = ~clk;

    assign sda_bus = ~(m_low | sda_oe);

    eepw_target #(
        .MEM_AW   (AW),
        .WR_CYCLES(WRC)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_sel(strap),
        .scl_in   (m_scl),
        .sda_in   (sda_bus),
        .sda_oe   (sda_oe),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    int       n_chk = 0;
    int       n_fail = 0;
    bit       done = 1'b0;
    logic [7:0] exp_mem [MEMN];
    bit       known [MEMN];
    logic [7:0] dbuf [80];

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_byte(input logic [1:0] s, input logic rw);
        return {5'b10100, s, rw};
    endfunction

    function automatic int slot(input int base, input int i);
        return (base & ~63) | ((base + i) & 63);
    endfunction

    task automatic bus_start;
        m_low = 1'b0; wc(HP / 2);
        m_scl = 1'b1; wc(HP);
        m_low = 1'b1; wc(HP);
        m_scl = 1'b0; wc(HP / 2);
    endtask

    task automatic bus_stop;
        m_low = 1'b1; wc(HP / 2);
        m_scl = 1'b1; wc(HP);
        m_low = 1'b0; wc(HP);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; wc(HP / 2);
        m_scl = 1'b1; wc(HP);
        m_scl = 1'b0; wc(HP / 2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; wc(HP / 2);
        m_scl = 1'b1; wc(HP / 2);
        acked = (sda_bus == 1'b0);
        wc(HP / 2);
        m_scl = 1'b0; wc(HP / 2);
    endtask

    task automatic poll(output int nacks);
        logic a;
        a = 1'b0;
        nacks = 0;
        for (int k = 0; k < 40 && !a; k++) begin
            bus_start;
            send_byte(dev_byte(strap, 1'b0), a);
            if (!a) nacks++;
        end
        bus_stop;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        rd_addr = AW'(a);
        wc(1);
        d = rd_data;
    endtask

    task automatic verify_page(input int base, input string req);
        logic [7:0] d;
        for (int o = 0; o < 64; o++) begin
            int loc;
            loc = (base & ~63) | o;
            if (known[loc]) begin
                rd(loc, d);
                check(req, $sformatf("R10 array byte at %0h", loc), d, exp_mem[loc]);
            end
        end
    endtask

    // kind: 0 normal stop, 1 stop mid data byte, 2 stop before data, 3 repeated start
    task automatic xfer(input logic [15:0] a16, input int n, input int kind, input string req);
        logic a;
        int   nacks;
        int   base;
        base = int'(a16[AW-1:0]);
        bus_start;
        send_byte(dev_byte(strap, 1'b0), a);
        check("R1", "device address ack", a, 1);
        send_byte(a16[15:8], a);
        check("R2", "high address ack", a, 1);
        send_byte(a16[7:0], a);
        check("R2", "low address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(dbuf[i], a);
            check("R3", "data byte ack", a, 1);
        end
        case (kind)
            0: begin
                bus_stop;
                for (int i = 0; i < n; i++) begin
                    exp_mem[slot(base, i)] = dbuf[i];
                    known[slot(base, i)]   = 1'b1;
                end
                poll(nacks);
                check("R8", "first poll refused while busy", (nacks >= 1), 1);
                check("R8", "acknowledged again after busy cycle", (nacks <= MAX_NACKS), 1);
            end
            1: begin
                send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
                bus_stop;
                poll(nacks);
                check("R6", "no busy cycle after mid-byte stop", nacks, 0);
            end
            2: begin
                bus_stop;
                poll(nacks);
                check("R6", "no busy cycle after stop without data", nacks, 0);
            end
            default: begin
                bus_start;
                bus_stop;
                poll(nacks);
                check("R7", "no busy cycle after repeated start", nacks, 0);
            end
        endcase
        verify_page(base, req);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic a;
        int   nacks;
        void'($urandom(32'd4711));
        for (int i = 0; i < MEMN; i++) begin
            known[i]   = 1'b0;
            exp_mem[i] = 8'h00;
        end

        // R11 reset state
        wc(4);
        check("R11", "sda_oe during reset", sda_oe, 0);
        rst_n = 1'b1;
        wc(6);
        check("R11", "sda_oe after reset", sda_oe, 0);

        // R5 fill page 3 completely
        for (int i = 0; i < 64; i++) dbuf[i] = 8'(i * 7 + 3);
        xfer(16'(3 * 64), 64, 0, "R5");

        // R3 wrap: 12 bytes from offset 60 of page 3
        for (int i = 0; i < 12; i++) dbuf[i] = 8'(8'hA0 + i);
        xfer(16'(3 * 64 + 60), 12, 0, "R3");

        // R4 more than 64 bytes from offset 10 of page 5
        for (int i = 0; i < 70; i++) dbuf[i] = 8'(i + 8'h40);
        xfer(16'(5 * 64 + 10), 70, 0, "R4");

        // R2 unused upper address bits set
        for (int i = 0; i < 5; i++) dbuf[i] = 8'(8'hC1 + i);
        xfer({5'b10110, 11'(6 * 64 + 20)}, 5, 0, "R2");

        // R6 stop mid data byte, then stop before data; R7 repeated start
        for (int i = 0; i < 3; i++) dbuf[i] = 8'hEE;
        xfer(16'(3 * 64 + 2), 2, 1, "R6");
        xfer(16'(3 * 64 + 2), 0, 2, "R6");
        xfer(16'(3 * 64 + 2), 2, 3, "R7");

        // R1 strap mismatch: nothing acknowledged, nothing written
        bus_start;
        send_byte(dev_byte(~strap, 1'b0), a);
        check("R1", "strap mismatch device ack", a, 0);
        send_byte(8'h00, a);
        check("R1", "address after rejected device", a, 0);
        send_byte(8'hC4, a);
        check("R1", "address after rejected device", a, 0);
        send_byte(8'h55, a);
        check("R1", "data after rejected device", a, 0);
        bus_stop;
        poll(nacks);
        check("R1", "no busy after rejected transfer", nacks, 0);
        verify_page(3 * 64, "R1");

        // R9 direction bit 1
        bus_start;
        send_byte(dev_byte(strap, 1'b1), a);
        check("R9", "read direction not acknowledged", a, 0);
        bus_stop;

        // Constrained random transfers
        for (int it = 0; it < 16; it++) begin
            int page, off, n, kind, k;
            page = int'($urandom_range(8, 1));
            off  = int'($urandom_range(63, 0));
            n    = ($urandom_range(4, 0) == 0) ? int'($urandom_range(70, 65))
                                               : int'($urandom_range(16, 1));
            k    = int'($urandom_range(5, 0));
            kind = (k <= 2) ? 0 : (k - 2);
            if (kind == 2) n = 0;
            for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
            xfer({5'($urandom), 11'(page * 64 + off)}, n, kind,
                 (kind == 0) ? ((n > 64) ? "R4" : "R5") : ((kind == 3) ? "R7" : "R6"));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule